// File: doc/BRIEF.md
# Strobe-Driven Receive Latch with Silence Timeout

This block is the receive end of a one-bit isolated link. The sending side never carries a level across the barrier. It sends short strobes instead: a set strobe when its input goes high and a reset strobe when it goes low. While its input is idle it repeats these strobes periodically. This block turns the strobes back into a level by holding a two-state latch.

A silence timer guards the latch. If neither kind of strobe is seen for a parameterised number of clock cycles, the block assumes the sending side has lost power or stopped working, and it forces the decoded level low. The next strobe of either kind clears that forced low at once.

A two-bit code describes the output-side supply, and a final stage uses it:
- In the off state, the output is released (high-impedance, output-enable low).
- In the bias-only state, the output is driven low.
- When the supply is fully up, the output shows the decoded level.

Top module: `pulse_decoder_wd`

## Requirements
- R1: A set strobe (with no reset strobe) captured at a clock edge makes `data_o` read 1 from that edge on, when `supply_st` is 2'b10 or 2'b11.
- R2: A reset strobe (with no set strobe) captured at a clock edge makes `data_o` read 0 from that edge on.
- R3: Between strobes the decoded level holds unchanged, as long as the silence timeout has not elapsed.
- R4: When set and reset strobes are captured at the same edge, the latch keeps its previous value.
- R5: When the last strobe was captured at edge k and no strobe follows, `data_o` reads 0 from edge k+TIMEOUT on. It still shows the latch at edges up to k+TIMEOUT-1.
- R6: A strobe of any kind, including a simultaneous set and reset pair, restarts the silence count.
- R7: After a timeout, the latch state is not shown until a new strobe arrives. A set strobe then restores a 1 at the edge that captures it.
- R8: With `supply_st` = 2'b00 (off), `oe_o` is 0 and `data_o` is 0.
- R9: With `supply_st` = 2'b01 (bias only), `oe_o` is 1 and `data_o` is 0.
- R10: With `supply_st` = 2'b10 or 2'b11 (fully up), `oe_o` is 1 and `data_o` equals the decoded level.
- R11: After reset, the latch is 0 and the timer is already expired, so `data_o` reads 0 until the first strobe.
- R12: The supply state changes neither the latch nor the timer. When the supply returns to fully up, the decoded level reappears with no new strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_stb | input | 1 | One-cycle strobe that sets the latch |
| clr_stb | input | 1 | One-cycle strobe that clears the latch |
| supply_st | input | 2 | Output supply state: 00 off, 01 bias only, 10/11 fully up |
| data_o | output | 1 | Decoded data; 0 whenever `oe_o` is 0 |
| oe_o | output | 1 | Output driver enable; low only in the off supply state |

## Verification
A latch stuck at the wrong value shows up on `data_o` at the first strobe-capturing edge while the supply is fully up. A timer that counts off by one moves the forced low by one cycle, so the bench samples exactly at edges k+TIMEOUT-1 and k+TIMEOUT. A restart that ignores the simultaneous strobe pair, or a latch wrongly cleared on timeout, appears as a 0 where a 1 is expected, up to TIMEOUT cycles later. Supply decoding faults are visible on `oe_o` and `data_o` in the same cycle the code changes.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  // Output-side supply condition as reported by the supply monitor.
  typedef enum logic [1:0] {
    SUP_OFF   = 2'b00,
    SUP_BIAS  = 2'b01,
    SUP_FULL  = 2'b10,
    SUP_FULL2 = 2'b11
  } supply_e;

  function automatic logic sup_driven(input logic [1:0] s);
    return s != SUP_OFF;
  endfunction

  function automatic logic sup_live(input logic [1:0] s);
    return s[1];
  endfunction

endpackage

// File: rtl/pdw_latch.sv
module pdw_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_stb,
  input  logic clr_stb,
  output logic q
);

  logic q_d;
  logic q_en;

  // Only a lone strobe moves the latch; a pair leaves it alone.
  always_comb begin
    q_en = set_stb ^ clr_stb;
    q_d  = set_stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= 1'b0;
    else if (q_en) q <= q_d;
  end

endmodule

// File: rtl/pdw_silence_timer.sv
module pdw_silence_timer #(
  parameter int unsigned TIMEOUT = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic expired
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    expired = (cnt_q == LIMIT);
    cnt_en  = kick || !expired;
    cnt_d   = kick ? '0 : (cnt_q + ONE);
  end

  // Held at the limit through reset: the link counts as silent at start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LIMIT;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pdw_out_stage.sv
module pdw_out_stage
  import pdw_pkg::*;
(
  input  logic [1:0] supply_st,
  input  logic       level,
  output logic       data_o,
  output logic       oe_o
);

  always_comb begin
    oe_o   = sup_driven(supply_st);
    data_o = sup_live(supply_st) ? level : 1'b0;
  end

endmodule

// File: rtl/pulse_decoder_wd.sv
module pulse_decoder_wd #(
  parameter int unsigned TIMEOUT   = 625,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_stb,
  input  logic       clr_stb,
  input  logic [1:0] supply_st,
  output logic       data_o,
  output logic       oe_o
);

  logic [SYNC_DEPTH-1:0] rst_sync_q;
  logic                  rst_int_n;
  logic                  latch_q;
  logic                  expired;
  logic                  level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_DEPTH-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_DEPTH-1];

  pdw_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .set_stb (set_stb),
    .clr_stb (clr_stb),
    .q       (latch_q)
  );

  pdw_silence_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .kick    (set_stb | clr_stb),
    .expired (expired)
  );

  assign level = latch_q & ~expired;

  pdw_out_stage u_out (
    .supply_st (supply_st),
    .level     (level),
    .data_o    (data_o),
    .oe_o      (oe_o)
  );

endmodule

// File: rtl/pulse_decoder_wd_chk.sv
module pulse_decoder_wd_chk #(
  parameter int unsigned TIMEOUT = 625
) (
  input logic       clk,
  input logic       rst_n,
  input logic       set_stb,
  input logic       clr_stb,
  input logic [1:0] supply_st,
  input logic       data_o,
  input logic       oe_o,
  input logic       latch_q
);

  int unsigned idle_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   idle_q <= TIMEOUT;
    else if (set_stb || clr_stb)  idle_q <= 0;
    else if (idle_q < TIMEOUT)    idle_q <= idle_q + 1;
  end

  AST_SET_SHOWS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && !clr_stb) |=> (data_o || !supply_st[1])); // R1

  AST_CLR_SHOWS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !set_stb) |=> !data_o); // R2

  AST_PAIR_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (set_stb && clr_stb) |=> $stable(latch_q)); // R4

  AST_SILENCE_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_q >= TIMEOUT) |-> !data_o); // R5

  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_st == 2'b00) |-> (!oe_o && !data_o)); // R8

  AST_BIAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_st == 2'b01) |-> (oe_o && !data_o)); // R9

  AST_FULL_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    supply_st[1] |-> oe_o); // R10

endmodule

bind pulse_decoder_wd pulse_decoder_wd_chk #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .set_stb   (set_stb),
  .clr_stb   (clr_stb),
  .supply_st (supply_st),
  .data_o    (data_o),
  .oe_o      (oe_o),
  .latch_q   (latch_q)
);

// File: tb/pulse_decoder_wd_tb.sv
`timescale 1ns/1ps
module pulse_decoder_wd_tb;

  localparam int unsigned WD = 40;

  logic       clk;
  logic       rst_n;
  logic       set_stb;
  logic       clr_stb;
  logic [1:0] supply_st;
  logic       data_o;
  logic       oe_o;

  int n_cmp;
  int n_bad;
  bit done;

  pulse_decoder_wd #(.TIMEOUT(WD)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_stb   (set_stb),
    .clr_stb   (clr_stb),
    .supply_st (supply_st),
    .data_o    (data_o),
    .oe_o      (oe_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one strobe cycle; returns just after the capturing edge.
  task automatic strobe(input logic s, input logic c);
    @(posedge clk); #1;
    set_stb = s; clr_stb = c;
    @(posedge clk); #1;
    set_stb = 0; clr_stb = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
  endtask

  task automatic look;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 0; set_stb = 0; clr_stb = 0; supply_st = 2'b10;
    idle(3); look;
    check("R11 data in reset", data_o, 1'b0);
    check("R11 oe in reset", oe_o, 1'b1);
    #1 rst_n = 1;
    idle(5); look;
    check("R11 data before first strobe", data_o, 1'b0);
  endtask

  task automatic t_set_clr;
    strobe(1, 0); look;
    check("R1 set", data_o, 1'b1);
    strobe(0, 1); look;
    check("R2 clr", data_o, 1'b0);
    strobe(1, 0); look;
    check("R1 set again", data_o, 1'b1);
  endtask

  task automatic t_hold;
    strobe(1, 0);
    idle(10); look;
    check("R3 hold high", data_o, 1'b1);
    strobe(0, 1);
    idle(10); look;
    check("R3 hold low", data_o, 1'b0);
  endtask

  task automatic t_pair;
    strobe(1, 1); look;
    check("R4 pair keeps 0", data_o, 1'b0);
    strobe(1, 0);
    strobe(1, 1); look;
    check("R4 pair keeps 1", data_o, 1'b1);
  endtask

  task automatic t_timeout;
    strobe(1, 0);
    idle(WD - 1); look;
    check("R5 still high at k+T-1", data_o, 1'b1);
    idle(1); look;
    check("R5 low at k+T", data_o, 1'b0);
    idle(5); look;
    check("R7 stays low while silent", data_o, 1'b0);
  endtask

  task automatic t_recover;
    // Latch still holds 1 behind the timeout; a pair restores it.
    strobe(1, 1); look;
    check("R7 pair reveals kept latch", data_o, 1'b1);
    idle(WD + 2);
    strobe(1, 0); look;
    check("R7 set restores high", data_o, 1'b1);
  endtask

  task automatic t_restart;
    strobe(1, 0);
    idle(WD - 6);
    strobe(1, 1);
    idle(WD - 1); look;
    check("R6 pair restarted count", data_o, 1'b1);
    idle(1); look;
    check("R6 expiry after restart", data_o, 1'b0);
  endtask

  task automatic t_supply;
    strobe(1, 0);
    @(posedge clk); #1 supply_st = 2'b00; look;
    check("R8 oe off", oe_o, 1'b0);
    check("R8 data off", data_o, 1'b0);
    @(posedge clk); #1 supply_st = 2'b01; look;
    check("R9 oe bias", oe_o, 1'b1);
    check("R9 data bias", data_o, 1'b0);
    @(posedge clk); #1 supply_st = 2'b11; look;
    check("R10 oe full", oe_o, 1'b1);
    check("R12 level back on 11", data_o, 1'b1);
    @(posedge clk); #1 supply_st = 2'b10; look;
    check("R10 data on 10", data_o, 1'b1);
    strobe(0, 1); look;
    check("R10 follows clr", data_o, 1'b0);
    @(posedge clk); #1 supply_st = 2'b00;
    strobe(1, 0);
    @(posedge clk); #1 supply_st = 2'b10; look;
    check("R12 set during off shown", data_o, 1'b1);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    t_reset;
    t_set_clr;
    t_hold;
    t_pair;
    t_timeout;
    t_recover;
    t_restart;
    t_supply;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule